// File: doc/BRIEF.md
# NAND Page Array with Bit-Clearing Program and Block Erase

This block is a synthesizable storage model of a small NAND cell array. The array is made of pages, and each page has a main area plus a spare area. The spare area is one thirty-second the size of the main area. A command front-end first fills a page buffer through a byte stream. The buffer is set to all ones and given a start column, and the bytes are then written from that column. The front-end then issues a program, erase or read request against a page index.

A program merges the buffer into the addressed page with a bitwise AND, so a cell bit can only fall from 1 to 0. An erase restores a whole block of pages to all ones. A read copies one page into a read buffer, which then streams out on a valid/ready interface. While a program or erase runs, the block reports busy for a fixed number of cycles and ignores new work.

Both streams follow valid/ready rules. A byte moves on a clock edge where valid and ready are both high.

- On the load side, ready is low only while busy. There is no other back-pressure.
- On the read side, the sink may hold ready low for any number of cycles. The data and valid then stay frozen until the byte is taken.

Top module: `nandx_array_core`

## Requirements
- R1: After reset every cell of every page reads 0xFF, no read data is pending, and status equals {wp_n, 1'b1, 5'b0, 1'b0}. Bit 7 always mirrors wp_n, bit 6 is 1 when ready, and bit 0 is the error flag.
- R2: An accepted program (op_kind 2'b10) replaces each byte of the page with the old byte AND the buffered byte, so bits only move from 1 to 0.
- R3: A pulse on ld_start fills the whole page buffer with 0xFF and sets the write column to ld_col. Each later byte taken on the load stream goes to the current column, which then advances by one. Bytes taken at a column at or past main plus spare size are accepted but dropped.
- R4: The spare area holds PAGE_BYTES>>5 bytes (2 at the default 64-byte page). A read (op_kind 2'b01) streams main plus spare bytes (66 by default) from column 0 upward, and rd_last is high on the final byte only.
- R5: An accepted erase (op_kind 2'b11) sets every byte of every page in the block to 0xFF. The block is the page index with its low PPB_LOG2 bits cleared. Pages outside that block keep their contents.
- R6: A program or erase requested while wp_n is low leaves the array unchanged, does not raise busy, and sets status bit 0. The next accepted program or erase clears status bit 0.
- R7: A program, erase or read whose page index is not below NUM_PAGES is ignored. It causes no busy, no change to the array or to status, and no read data.
- R8: An accepted program or erase holds status bit 6 low for exactly BUSY_CYCLES cycles, starting on the edge after acceptance.
- R9: While busy, op_go and ld_start have no effect, ld_ready is low, and bytes offered on the load stream do not reach the page buffer.
- R10: While rd_valid is high and rd_ready is low, rd_valid, rd_data and rd_last hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wp_n | input | 1 | Write protect, active low |
| op_go | input | 1 | One-cycle request strobe |
| op_kind | input | 2 | 01 read, 10 program, 11 erase, 00 none |
| op_page | input | PG_W | Page index of the request |
| ld_start | input | 1 | Clear page buffer and set start column |
| ld_col | input | COL_W | Start column for the load stream |
| ld_valid | input | 1 | Load byte valid |
| ld_ready | output | 1 | Load byte can be taken |
| ld_data | input | 8 | Load byte |
| rd_valid | output | 1 | Read byte valid |
| rd_ready | input | 1 | Read sink can take a byte |
| rd_data | output | 8 | Read byte |
| rd_last | output | 1 | Final byte of the page |
| status | output | 8 | {wp_n, ready, 5'b0, error} |

## Verification
The hardest case to reach from the ports is proving that work offered inside the busy window leaves no trace, because the page buffer cannot be observed directly. The stimulus runs in three steps.

1. It programs one page.
2. During the busy window it fires a competing program, a read, a fresh ld_start and zero bytes on the load stream.
3. After busy ends, it programs a second page without reloading.

Only the old buffer contents can then explain what lands in the second page. A write-protect reject followed by an accepted operation shows the error flag both setting and clearing.

// File: rtl/nandx_pkg.sv
package nandx_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_READ  = 2'b01,
    OP_PROG  = 2'b10,
    OP_ERASE = 2'b11
  } nandx_op_e;

  function automatic int spare_of(input int page_bytes);
    return page_bytes >> 5;
  endfunction
endpackage

// File: rtl/nandx_pagebuf.sv
module nandx_pagebuf #(
  parameter int TOTAL = 66,
  parameter int COL_W = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  hold,
  input  logic                  start,
  input  logic [COL_W-1:0]      start_col,
  input  logic                  ld_valid,
  input  logic [7:0]            ld_data,
  output logic                  ld_ready,
  output logic [TOTAL-1:0][7:0] buf_q
);
  localparam int IDX_W = $clog2(TOTAL);

  logic [COL_W-1:0] col_q;
  logic             in_page;

  assign ld_ready = !hold;
  assign in_page  = col_q < COL_W'(TOTAL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q <= '1;
      col_q <= '0;
    end else if (!hold) begin
      if (start) begin
        buf_q <= '1;
        col_q <= start_col;
      end else if (ld_valid && in_page) begin
        buf_q[col_q[IDX_W-1:0]] <= ld_data;
        col_q <= col_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/nandx_cells.sv
module nandx_cells #(
  parameter int NUM_PAGES = 12,
  parameter int PG_W      = 4,
  parameter int PPB_LOG2  = 2,
  parameter int TOTAL     = 66
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  prog_en,
  input  logic                  erase_en,
  input  logic [PG_W-1:0]       page,
  input  logic [TOTAL-1:0][7:0] buf_q,
  output logic [TOTAL-1:0][7:0] pg_q
);
  logic [TOTAL-1:0][7:0] mem [NUM_PAGES];

  for (genvar g = 0; g < NUM_PAGES; g++) begin : g_page
    localparam logic [PG_W-1:0] GI = PG_W'(g);
    logic same_blk;
    assign same_blk = GI[PG_W-1:PPB_LOG2] == page[PG_W-1:PPB_LOG2];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mem[g] <= '1;
      end else if (erase_en && same_blk) begin
        mem[g] <= '1;
      end else if (prog_en && page == GI) begin
        mem[g] <= mem[g] & buf_q;
      end
    end
  end

  always_comb begin
    pg_q = '1;
    for (int i = 0; i < NUM_PAGES; i++) begin
      if (page == PG_W'(i)) pg_q = mem[i];
    end
  end
endmodule

// File: rtl/nandx_busy_timer.sv
module nandx_busy_timer #(
  parameter int BUSY_CYCLES = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (start)         cnt_q <= CNT_W'(BUSY_CYCLES);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy = cnt_q != '0;
endmodule

// File: rtl/nandx_rdstream.sv
module nandx_rdstream #(
  parameter int TOTAL = 66
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [TOTAL-1:0][7:0] page_in,
  output logic                  rd_valid,
  input  logic                  rd_ready,
  output logic [7:0]            rd_data,
  output logic                  rd_last
);
  localparam int IDX_W = $clog2(TOTAL);

  logic [TOTAL-1:0][7:0] rbuf_q;
  logic [IDX_W-1:0]      ptr_q;
  logic                  act_q;
  logic                  at_end;

  assign at_end = ptr_q == IDX_W'(TOTAL - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rbuf_q <= '1;
      ptr_q  <= '0;
      act_q  <= 1'b0;
    end else if (load) begin
      rbuf_q <= page_in;
      ptr_q  <= '0;
      act_q  <= 1'b1;
    end else if (act_q && rd_ready) begin
      if (at_end) act_q <= 1'b0;
      else        ptr_q <= ptr_q + 1'b1;
    end
  end

  assign rd_valid = act_q;
  assign rd_data  = rbuf_q[ptr_q];
  assign rd_last  = act_q && at_end;
endmodule

// File: rtl/nandx_array_core.sv
module nandx_array_core
  import nandx_pkg::*;
#(
  parameter int PAGE_BYTES  = 64,
  parameter int NUM_PAGES   = 12,
  parameter int PPB_LOG2    = 2,
  parameter int BUSY_CYCLES = 6,
  parameter int PG_W        = $clog2(NUM_PAGES + 1),
  parameter int COL_W       = $clog2(PAGE_BYTES + (PAGE_BYTES >> 5) + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wp_n,
  input  logic             op_go,
  input  logic [1:0]       op_kind,
  input  logic [PG_W-1:0]  op_page,
  input  logic             ld_start,
  input  logic [COL_W-1:0] ld_col,
  input  logic             ld_valid,
  output logic             ld_ready,
  input  logic [7:0]       ld_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_data,
  output logic             rd_last,
  output logic [7:0]       status
);
  localparam int SPARE_BYTES = spare_of(PAGE_BYTES);
  localparam int TOTAL       = PAGE_BYTES + SPARE_BYTES;

  nandx_op_e             kind;
  logic                  busy, in_range, idle_go, wr_req, wr_ok, wr_rej;
  logic                  prog_en, erase_en, rd_load, err_q;
  logic [TOTAL-1:0][7:0] buf_q, pg_q;

  assign kind     = nandx_op_e'(op_kind);
  assign in_range = op_page < PG_W'(NUM_PAGES);
  assign idle_go  = op_go && !busy && in_range;
  assign wr_req   = idle_go && (kind == OP_PROG || kind == OP_ERASE);
  assign wr_ok    = wr_req && wp_n;
  assign wr_rej   = wr_req && !wp_n;
  assign prog_en  = wr_ok && kind == OP_PROG;
  assign erase_en = wr_ok && kind == OP_ERASE;
  assign rd_load  = idle_go && kind == OP_READ;

  always_ff @(posedge clk) begin
    if (!rst_n)      err_q <= 1'b0;
    else if (wr_rej) err_q <= 1'b1;
    else if (wr_ok)  err_q <= 1'b0;
  end

  assign status = {wp_n, !busy, 5'b0, err_q};

  nandx_pagebuf #(.TOTAL(TOTAL), .COL_W(COL_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .hold(busy), .start(ld_start),
    .start_col(ld_col), .ld_valid(ld_valid), .ld_data(ld_data),
    .ld_ready(ld_ready), .buf_q(buf_q)
  );

  nandx_cells #(
    .NUM_PAGES(NUM_PAGES), .PG_W(PG_W), .PPB_LOG2(PPB_LOG2), .TOTAL(TOTAL)
  ) u_cells (
    .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .erase_en(erase_en),
    .page(op_page), .buf_q(buf_q), .pg_q(pg_q)
  );

  nandx_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
    .clk(clk), .rst_n(rst_n), .start(wr_ok), .busy(busy)
  );

  nandx_rdstream #(.TOTAL(TOTAL)) u_rd (
    .clk(clk), .rst_n(rst_n), .load(rd_load), .page_in(pg_q),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .rd_last(rd_last)
  );
endmodule

// File: rtl/nandx_array_chk.sv
module nandx_array_chk #(
  parameter int NUM_PAGES   = 12,
  parameter int BUSY_CYCLES = 6,
  parameter int PG_W        = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wp_n,
  input logic            op_go,
  input logic [1:0]      op_kind,
  input logic [PG_W-1:0] op_page,
  input logic            rd_valid,
  input logic            rd_ready,
  input logic [7:0]      rd_data,
  input logic            rd_last,
  input logic            rdy,
  input logic            err
);
  logic [15:0] busy_run;
  logic        wr_try, rd_try;

  assign wr_try = op_go && rdy && op_kind[1] && (op_page < PG_W'(NUM_PAGES));
  assign rd_try = op_go && rdy && op_kind == 2'b01 && (op_page < PG_W'(NUM_PAGES));

  always_ff @(posedge clk) begin
    if (!rst_n)   busy_run <= '0;
    else if (!rdy) busy_run <= busy_run + 1'b1;
    else          busy_run <= '0;
  end

  p_reject_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_try && !wp_n) |=> (err && rdy));

  p_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_try && wp_n) |=> (!rdy && !err));

  p_busy_length_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy) |-> busy_run == 16'(BUSY_CYCLES));

  p_err_frozen_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy |=> $stable(err));

  p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !rd_try) |=>
      (rd_valid && $stable(rd_data) && $stable(rd_last)));

  p_last_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && rd_last && !rd_try) |=> !rd_valid);
endmodule

bind nandx_array_core nandx_array_chk #(
  .NUM_PAGES(NUM_PAGES), .BUSY_CYCLES(BUSY_CYCLES), .PG_W(PG_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .op_go(op_go), .op_kind(op_kind),
  .op_page(op_page), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .rd_data(rd_data), .rd_last(rd_last), .rdy(status[6]), .err(status[0])
);

// File: tb/test_nandx_array_core.sv
module test_nandx_array_core;
  localparam int PB  = 64;
  localparam int TOT = PB + (PB >> 5);
  localparam int NP  = 12;
  localparam int BC  = 6;
  localparam int PGW = 4;
  localparam int CW  = 7;

  // {kind, wp, page, col, count, seed}; kind 2 = program, 3 = erase
  localparam logic [35:0] VEC [11] = '{
    36'h2_1_1_00_42_3C,
    36'h2_1_1_00_42_A5,
    36'h2_1_2_3E_08_11,
    36'h2_1_5_0A_05_77,
    36'h2_1_6_00_42_5A,
    36'h3_1_6_00_00_00,
    36'h2_0_1_00_42_00,
    36'h3_0_0_00_00_00,
    36'h2_1_B_00_42_C3,
    36'h3_1_D_00_00_00,
    36'h2_1_C_00_42_00
  };

  logic clk = 0, rst_n = 0, wp_n = 1, op_go = 0, ld_start = 0, ld_valid = 0, rd_ready = 1;
  logic [1:0] op_kind = 0;
  logic [PGW-1:0] op_page = 0;
  logic [CW-1:0] ld_col = 0;
  logic [7:0] ld_data = 0;
  logic ld_ready, rd_valid, rd_last;
  logic [7:0] rd_data, status;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] model [NP][TOT];
  logic [7:0] mbuf [TOT];
  bit merr = 0;

  always #2 clk = ~clk;

  nandx_array_core i_nandx_array_core (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .op_go(op_go), .op_kind(op_kind),
    .op_page(op_page), .ld_start(ld_start), .ld_col(ld_col), .ld_valid(ld_valid),
    .ld_ready(ld_ready), .ld_data(ld_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .rd_last(rd_last), .status(status)
  );

  function automatic logic [7:0] pat(input logic [7:0] seed, input int i);
    logic [7:0] b = 8'(i);
    return 8'(seed + i * 37) ^ {b[3:0], b[7:4]};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(input int col, input int n, input logic [7:0] seed);
    @(negedge clk); ld_start = 1; ld_col = CW'(col);
    @(negedge clk); ld_start = 0;
    for (int i = 0; i < TOT; i++) mbuf[i] = 8'hFF;
    for (int i = 0; i < n; i++) begin
      ld_valid = 1; ld_data = pat(seed, i);
      if (col + i < TOT) mbuf[col + i] = pat(seed, i);
      @(negedge clk);
    end
    ld_valid = 0;
  endtask

  task automatic issue(input logic [1:0] k, input int p);
    @(negedge clk); op_go = 1; op_kind = k; op_page = PGW'(p);
    @(negedge clk); op_go = 0; op_kind = 0;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 100 && !status[6]; i++) @(negedge clk);
  endtask

  task automatic read_page(input int p, output int nb, output int mism, output bit last_ok);
    rd_ready = 1;
    issue(2'b01, p);
    nb = 0; mism = 0; last_ok = 1;
    for (int k = 0; k < TOT + 4; k++) begin
      if (rd_valid) begin
        if (nb < TOT && rd_data !== model[p][nb]) mism++;
        if (rd_last != (nb == TOT - 1)) last_ok = 0;
        nb++;
      end
      @(negedge clk);
    end
  endtask

  task automatic check_all(input string req);
    int nb, mism, tot_m; bit lok, all_lok;
    tot_m = 0; all_lok = 1;
    for (int p = 0; p < NP; p++) begin
      read_page(p, nb, mism, lok);
      tot_m += mism;
      if (nb != TOT || !lok) all_lok = 0;
    end
    check(tot_m == 0 && all_lok, req, tot_m, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    int nb, mism, n; bit lok;
    logic [7:0] d0;
    for (int p = 0; p < NP; p++) for (int i = 0; i < TOT; i++) model[p][i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(status == 8'hC0, "R1 status", status, 8'hC0);
    check(ld_ready && !rd_valid, "R1 idle ports", {ld_ready, rd_valid}, 2'b10);
    check_all("R1 erased array");
    // R4 page length and spare size
    read_page(0, nb, mism, lok);
    check(nb == 66 && lok, "R4 bytes per page", nb, 66);

    // table walk: R2 R3 R5 R6 R7
    foreach (VEC[v]) begin
      logic [1:0] k; int p; logic [7:0] exp_st; bit acc;
      k = VEC[v][33:32]; p = int'(VEC[v][27:24]);
      if (k == 2'b10) load(int'(VEC[v][23:16]), int'(VEC[v][15:8]), VEC[v][7:0]);
      wp_n = VEC[v][28];
      acc = (p < NP) && wp_n;
      if (p < NP && !wp_n) merr = 1;
      else if (acc) merr = 0;
      issue(k, p);
      exp_st = {wp_n, !acc, 5'b0, merr};
      check(status == exp_st, "R6 R7 R8 status after request", status, exp_st);
      wait_ready();
      if (acc && k == 2'b10)
        for (int i = 0; i < TOT; i++) model[p][i] = model[p][i] & mbuf[i];
      if (acc && k == 2'b11)
        for (int q = p & ~3; q < (p & ~3) + 4; q++)
          if (q < NP) for (int i = 0; i < TOT; i++) model[q][i] = 8'hFF;
      wp_n = 1;
      check_all("R2 R3 R5 R6 R7 array contents");
    end

    // R1 bit 7 mirrors wp_n
    wp_n = 0; @(negedge clk);
    check(status[7] == 1'b0, "R1 wp mirror", status[7], 0);
    wp_n = 1; @(negedge clk);

    // R8 busy length
    load(0, TOT, 8'h99);
    issue(2'b10, 8);
    for (int i = 0; i < TOT; i++) model[8][i] = model[8][i] & mbuf[i];
    n = 0;
    // R9 ignored work during busy
    check(!ld_ready, "R9 ld_ready low while busy", ld_ready, 0);
    op_go = 1; op_kind = 2'b10; op_page = 9; ld_start = 1; ld_col = 0;
    ld_valid = 1; ld_data = 8'h00;
    @(negedge clk); n++;
    op_kind = 2'b01; ld_start = 0;
    @(negedge clk); n++;
    op_go = 0; ld_valid = 0;
    check(!rd_valid, "R9 read ignored while busy", rd_valid, 0);
    while (!status[6] && n < 50) begin n++; @(negedge clk); end
    check(n == BC, "R8 busy cycles", n, BC);
    issue(2'b10, 9);
    wait_ready();
    for (int i = 0; i < TOT; i++) model[9][i] = model[9][i] & mbuf[i];
    check_all("R9 buffer and page 9 untouched by busy-time work");

    // R10 back-pressure
    rd_ready = 0;
    issue(2'b01, 1);
    d0 = rd_data;
    repeat (3) @(negedge clk);
    check(rd_valid && rd_data == model[1][0] && d0 == model[1][0],
          "R10 hold under back-pressure", rd_data, model[1][0]);
    rd_ready = 1;
    n = 0;
    for (int k = 0; k < TOT + 4; k++) begin
      if (rd_valid) begin
        if (n < TOT && rd_data !== model[1][n]) mism++;
        n++;
      end
      @(negedge clk);
    end
    check(n == TOT, "R10 stream resumes in order", n, TOT);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule